// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor and merges two kinds of interrupt request into a single encoded priority level for the CPU. The first kind is a set of internal peripheral request strobes. The second kind is three active-low external pins. Each internal strobe sets a bit in a pending register. A mask register decides which pending bits may reach the processor. An in-service register records which internal sources are being handled, so that only a higher-ranked source can nest above them. All internal sources are presented at one fixed level, `INT_LEVEL`, and among them a higher source index outranks a lower one.

The external pins have two modes. In encoded mode they carry a three-bit priority level directly. In dedicated mode they act as three separate request lines for levels 7, 6 and 1. Each line can be level-sensitive or can latch a falling edge. When the CPU acknowledges a level, a small state machine selects the winning source. It then presents either an 8-bit vector or a flag that tells outside logic to supply the vector. Any acknowledge cycle that comes before software first writes the mode register returns the placeholder vector 0x0F.

Software reaches the block through a 16-bit register bus. The address decode is: 0 for mode, 1 for pending, 2 for mask and 3 for in-service. There are two resets. The full reset `sys_rst_n` clears everything. The soft reset `rst_n` clears everything except the mode register.

The acknowledge state machine has three states:
- `ST_IDLE` captures `iack_lvl` when `iack` rises and moves to `ST_RESOLVE`.
- `ST_RESOLVE` picks the source, registers the vector and applies the acknowledge side effects, then always moves to `ST_DRIVE`.
- `ST_DRIVE` presents the result while `iack` stays high and returns to `ST_IDLE` once `iack` is low.

Top module: `icu_top`

## Requirements
- R1: Mode register layout:
  - bit 15 is the dedicated-mode select.
  - bits 14/13/12 select an external vector for levels 7/6/1.
  - bits 10/9/8 select edge trigger for levels 7/6/1.
  - bits 7:5 are the vector base.
  - bits 11 and 4:0 always read 0.
  
  Only the full reset clears this register; the soft reset leaves it intact.
- R2: Until the mode register has been written once after a full reset, every internally supplied vector is 0x0F.
- R3: An internal strobe sets its pending bit even while its mask bit is 0 (0 means blocked). A blocked source never raises `ipl`.
- R4: Among unmasked pending internal sources, the highest index wins. Its vector is {vector base, 5-bit index}.
- R5: Acknowledging an internal source sets its in-service bit and clears its pending bit. Writing 1 to a bit of the pending or in-service register clears that bit.
- R6: An internal source is offered only when its index is strictly above every set in-service bit.
- R7: In encoded mode, `ipl` equals the inverted pins. Acknowledging that level asserts `ext_vec` and does not assert `vec_vld`.
- R8: In dedicated mode, pins 2/1/0 request levels 7/6/1. A line in edge mode latches a falling edge until it is acknowledged. A line in level mode is active while its pin is low.
- R9: For a dedicated line whose external-vector bit is 0, the vector is {base, 0x1F/0x1E/0x1D} for levels 7/6/1. When that bit is 1, `ext_vec` is asserted instead.
- R10: `ipl` is the highest qualifying level among the internal and external requests. It is 0 when nothing qualifies.
- R11: An acknowledge that matches no source returns vector {base, 0x1C}.
- R12: The result appears two clocks after `iack` rises and stays stable until the clock after `iack` falls. `vec_vld` and `ext_vec` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Full reset, active low, synchronous |
| rst_n | input | 1 | Soft reset, active low, synchronous; mode register kept |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 pending, 2 mask, 3 in-service |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| int_req | input | N_SRC | Internal request strobes, one per source |
| irq_pin_n | input | 3 | External request pins, active low |
| ipl | output | 3 | Encoded priority level to the CPU |
| iack | input | 1 | Interrupt acknowledge, held for the cycle |
| iack_lvl | input | 3 | Level being acknowledged |
| vec_vld | output | 1 | Internally supplied vector valid |
| vec | output | 8 | Vector number |
| ext_vec | output | 1 | Vector must come from outside |

## Verification
The assertions assume several things about the inputs:
- `iack` is held high long enough to reach `ST_DRIVE`.
- The mode register is not rewritten while a result is being presented.
- The pins are already synchronous to `clk`.

The stimulus follows these rules. Every input is changed on the falling edge. Each acknowledge is held for three cycles and released only after the result has been observed. All mode writes happen between acknowledge cycles. Edge-mode pulses on the pins are one full cycle wide.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_DRIVE
    } ack_st_t;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_PEND = 2'd1;
    localparam logic [1:0] A_MASK = 2'd2;
    localparam logic [1:0] A_INSV = 2'd3;

    localparam logic [7:0] VEC_UNSET = 8'h0F;
    localparam logic [4:0] SRC_L7    = 5'h1F;
    localparam logic [4:0] SRC_L6    = 5'h1E;
    localparam logic [4:0] SRC_L1    = 5'h1D;
    localparam logic [4:0] SRC_SPUR  = 5'h1C;

    // line order in 3-bit fields: [2] level 7, [1] level 6, [0] level 1
    typedef struct packed {
        logic       dedicated;
        logic [2:0] xvec_sel;
        logic [2:0] edge_sel;
        logic [2:0] vbase;
    } mode_t;
endpackage

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             soft_rst,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [15:0]      wdata,
    input  logic [N_SRC-1:0] int_req,
    input  logic [N_SRC-1:0] ack_int,
    output mode_t            mode_q,
    output logic             base_set,
    output logic [N_SRC-1:0] pend,
    output logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] insv,
    output logic [15:0]      rdata
);
    logic             unused_wd;
    logic [N_SRC-1:0] pend_clr;
    logic [N_SRC-1:0] insv_clr;

    assign unused_wd = ^wdata;
    assign pend_clr  = ack_int | ((wr && addr == A_PEND) ? wdata[N_SRC-1:0] : '0);
    assign insv_clr  = (wr && addr == A_INSV) ? wdata[N_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            mode_q   <= '0;
            base_set <= 1'b0;
        end else if (wr && addr == A_MODE) begin
            mode_q.dedicated <= wdata[15];
            mode_q.xvec_sel  <= wdata[14:12];
            mode_q.edge_sel  <= wdata[10:8];
            mode_q.vbase     <= wdata[7:5];
            base_set         <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            pend <= '0;
            mask <= '0;
            insv <= '0;
        end else begin
            pend <= (pend & ~pend_clr) | int_req;
            insv <= (insv & ~insv_clr) | ack_int;
            if (wr && addr == A_MASK) begin
                mask <= wdata[N_SRC-1:0];
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_MODE:  rdata = {mode_q.dedicated, mode_q.xvec_sel, 1'b0,
                              mode_q.edge_sel, mode_q.vbase, 5'b0};
            A_PEND:  rdata = 16'(pend);
            A_MASK:  rdata = 16'(mask);
            default: rdata = 16'(insv);
        endcase
    end
endmodule

// File: rtl/icu_ext.sv
module icu_ext (
    input  logic       clk,
    input  logic       soft_rst,
    input  logic       dedicated,
    input  logic [2:0] edge_sel,
    input  logic [2:0] pin_n,
    input  logic [2:0] lat_clr,
    output logic [2:0] line_act,
    output logic [2:0] ext_lvl
);
    logic [2:0] prev_n;

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            prev_n <= 3'b111;
        end else begin
            prev_n <= pin_n;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_line
        logic lat;
        always_ff @(posedge clk) begin
            if (soft_rst || !dedicated || !edge_sel[g]) begin
                lat <= 1'b0;
            end else if (prev_n[g] && !pin_n[g]) begin
                lat <= 1'b1;
            end else if (lat_clr[g]) begin
                lat <= 1'b0;
            end
        end
        assign line_act[g] = dedicated && (edge_sel[g] ? lat : !pin_n[g]);
    end

    always_comb begin
        if (!dedicated)      ext_lvl = ~pin_n;
        else if (line_act[2]) ext_lvl = 3'd7;
        else if (line_act[1]) ext_lvl = 3'd6;
        else if (line_act[0]) ext_lvl = 3'd1;
        else                  ext_lvl = 3'd0;
    end
endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
    parameter int N_SRC     = 8,
    parameter int INT_LEVEL = 4
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] insv,
    input  logic [2:0]       ext_lvl,
    output logic             int_ok,
    output logic [4:0]       int_idx,
    output logic [2:0]       ipl
);
    localparam logic [2:0] LVL_INT = 3'(INT_LEVEL);

    logic [N_SRC-1:0] live;
    logic             int_any;
    logic             isr_any;
    logic [4:0]       isr_idx;
    logic [2:0]       int_lvl;

    assign live = pend & mask;

    always_comb begin
        int_any = 1'b0;
        int_idx = '0;
        isr_any = 1'b0;
        isr_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (live[i]) begin
                int_any = 1'b1;
                int_idx = 5'(i);
            end
            if (insv[i]) begin
                isr_any = 1'b1;
                isr_idx = 5'(i);
            end
        end
    end

    assign int_ok  = int_any && (!isr_any || int_idx > isr_idx);
    assign int_lvl = int_ok ? LVL_INT : 3'd0;
    assign ipl     = (ext_lvl > int_lvl) ? ext_lvl : int_lvl;
endmodule

// File: rtl/icu_ack_fsm.sv
module icu_ack_fsm
    import icu_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int INT_LEVEL = 4
) (
    input  logic             clk,
    input  logic             soft_rst,
    input  logic             iack,
    input  logic [2:0]       iack_lvl,
    input  mode_t            mode_q,
    input  logic             base_set,
    input  logic             int_ok,
    input  logic [4:0]       int_idx,
    input  logic [2:0]       line_act,
    input  logic [2:0]       ext_lvl,
    output logic [N_SRC-1:0] ack_int,
    output logic [2:0]       lat_clr,
    output logic             vec_vld,
    output logic [7:0]       vec,
    output logic             ext_vec
);
    localparam logic [2:0] LVL_INT = 3'(INT_LEVEL);
    localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

    ack_st_t    st, st_nx;
    logic [2:0] lvl_q;
    logic [7:0] vec_q;
    logic       ext_q;
    logic       take_int;
    logic       take_ext;
    logic [2:0] clr_d;
    logic [4:0] src;
    logic [7:0] vec_d;

    always_ff @(posedge clk) begin
        if (soft_rst) st <= ST_IDLE;
        else          st <= st_nx;
    end

    always_comb begin
        unique case (st)
            ST_IDLE:    st_nx = iack ? ST_RESOLVE : ST_IDLE;
            ST_RESOLVE: st_nx = ST_DRIVE;
            ST_DRIVE:   st_nx = iack ? ST_DRIVE : ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // source selection for the captured level
    always_comb begin
        take_int = 1'b0;
        take_ext = 1'b0;
        clr_d    = 3'b000;
        src      = SRC_SPUR;
        if (lvl_q == LVL_INT && int_ok) begin
            take_int = 1'b1;
            src      = int_idx;
        end else if (mode_q.dedicated && lvl_q == 3'd7 && line_act[2]) begin
            clr_d[2] = 1'b1;
            take_ext = mode_q.xvec_sel[2];
            src      = SRC_L7;
        end else if (mode_q.dedicated && lvl_q == 3'd6 && line_act[1]) begin
            clr_d[1] = 1'b1;
            take_ext = mode_q.xvec_sel[1];
            src      = SRC_L6;
        end else if (mode_q.dedicated && lvl_q == 3'd1 && line_act[0]) begin
            clr_d[0] = 1'b1;
            take_ext = mode_q.xvec_sel[0];
            src      = SRC_L1;
        end else if (!mode_q.dedicated && lvl_q != 3'd0 && lvl_q == ext_lvl) begin
            take_ext = 1'b1;
        end
        vec_d = base_set ? {mode_q.vbase, src} : VEC_UNSET;
    end

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            lvl_q <= '0;
            vec_q <= '0;
            ext_q <= 1'b0;
        end else begin
            if (st == ST_IDLE && iack) lvl_q <= iack_lvl;
            if (st == ST_RESOLVE) begin
                vec_q <= vec_d;
                ext_q <= take_ext;
            end
        end
    end

    always_comb begin
        ack_int = (st == ST_RESOLVE && take_int) ? (ONE << int_idx) : '0;
        lat_clr = (st == ST_RESOLVE) ? clr_d : 3'b000;
        vec_vld = (st == ST_DRIVE) && !ext_q;
        ext_vec = (st == ST_DRIVE) && ext_q;
        vec     = vec_vld ? vec_q : 8'h00;
    end
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int INT_LEVEL = 4
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [N_SRC-1:0] int_req,
    input  logic [2:0]       irq_pin_n,
    output logic [2:0]       ipl,
    input  logic             iack,
    input  logic [2:0]       iack_lvl,
    output logic             vec_vld,
    output logic [7:0]       vec,
    output logic             ext_vec
);
    logic             soft_rst;
    mode_t            mode_q;
    logic             base_set;
    logic             dedicated;
    logic [N_SRC-1:0] pend, mask, insv, ack_int;
    logic [2:0]       line_act, ext_lvl, lat_clr;
    logic             int_ok;
    logic [4:0]       int_idx;

    assign soft_rst  = !rst_n || !sys_rst_n;
    assign dedicated = mode_q.dedicated;

    icu_regs #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .sys_rst_n(sys_rst_n), .soft_rst(soft_rst),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .int_req(int_req), .ack_int(ack_int),
        .mode_q(mode_q), .base_set(base_set),
        .pend(pend), .mask(mask), .insv(insv), .rdata(reg_rdata)
    );

    icu_ext u_ext (
        .clk(clk), .soft_rst(soft_rst), .dedicated(dedicated),
        .edge_sel(mode_q.edge_sel), .pin_n(irq_pin_n), .lat_clr(lat_clr),
        .line_act(line_act), .ext_lvl(ext_lvl)
    );

    icu_prio #(.N_SRC(N_SRC), .INT_LEVEL(INT_LEVEL)) u_prio (
        .pend(pend), .mask(mask), .insv(insv), .ext_lvl(ext_lvl),
        .int_ok(int_ok), .int_idx(int_idx), .ipl(ipl)
    );

    icu_ack_fsm #(.N_SRC(N_SRC), .INT_LEVEL(INT_LEVEL)) u_fsm (
        .clk(clk), .soft_rst(soft_rst), .iack(iack), .iack_lvl(iack_lvl),
        .mode_q(mode_q), .base_set(base_set), .int_ok(int_ok),
        .int_idx(int_idx), .line_act(line_act), .ext_lvl(ext_lvl),
        .ack_int(ack_int), .lat_clr(lat_clr),
        .vec_vld(vec_vld), .vec(vec), .ext_vec(ext_vec)
    );
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             sys_rst_n,
    input logic             rst_n,
    input logic             iack,
    input logic             vec_vld,
    input logic             ext_vec,
    input logic [7:0]       vec,
    input logic             base_set,
    input logic [N_SRC-1:0] pend,
    input logic [N_SRC-1:0] mask,
    input logic             dedicated,
    input logic [2:0]       irq_pin_n,
    input logic [2:0]       ipl
);
    // R12
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
        !(vec_vld && ext_vec));

    // R12
    release_chk: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
        $fell(iack) |=> (!vec_vld && !ext_vec));

    // R12
    vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
        (vec_vld && $past(vec_vld)) |-> $stable(vec));

    // R2
    placeholder_chk: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
        (vec_vld && !base_set) |-> (vec == 8'h0F));

    // R10
    quiet_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
        (((pend & mask) == '0) && !dedicated && irq_pin_n == 3'b111) |-> (ipl == 3'd0));
endmodule

bind icu_top icu_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .sys_rst_n(sys_rst_n), .rst_n(rst_n), .iack(iack),
    .vec_vld(vec_vld), .ext_vec(ext_vec), .vec(vec), .base_set(base_set),
    .pend(pend), .mask(mask), .dedicated(dedicated),
    .irq_pin_n(irq_pin_n), .ipl(ipl)
);

// File: tb/tb_icu_top.sv
module tb_icu_top;
    localparam int N_SRC = 8;

    logic             clk = 1'b0;
    logic             sys_rst_n = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [15:0]      reg_wdata = 16'h0;
    logic [15:0]      reg_rdata;
    logic [N_SRC-1:0] int_req = '0;
    logic [2:0]       irq_pin_n = 3'b111;
    logic [2:0]       ipl;
    logic             iack = 1'b0;
    logic [2:0]       iack_lvl = 3'd0;
    logic             vec_vld;
    logic [7:0]       vec;
    logic             ext_vec;

    int checks = 0;
    int errors = 0;
    logic [8:0] expq[$];
    string      tagq[$];
    logic       busy = 1'b0;

    always #5 clk = ~clk;

    icu_top #(.N_SRC(N_SRC), .INT_LEVEL(4)) dut (
        .clk(clk), .sys_rst_n(sys_rst_n), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_req(int_req), .irq_pin_n(irq_pin_n),
        .ipl(ipl), .iack(iack), .iack_lvl(iack_lvl),
        .vec_vld(vec_vld), .vec(vec), .ext_vec(ext_vec)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one comparison per acknowledge result
    always @(negedge clk) begin
        if (!busy && (vec_vld || ext_vec)) begin
            busy = 1'b1;
            if (expq.size() == 0) begin
                chk("R12 unexpected result", {7'd0, ext_vec, vec}, 16'h1FF);
            end else begin
                chk(tagq.pop_front(), {7'd0, ext_vec, vec}, {7'd0, expq.pop_front()});
            end
        end else if (!vec_vld && !ext_vec) begin
            busy = 1'b0;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        int_req[idx] = 1'b1;
        @(negedge clk);
        int_req = '0;
    endtask

    task automatic see_ipl(input string req, input logic [2:0] exp);
        #1 chk(req, 16'(ipl), 16'(exp));
    endtask

    // driver: pushes the expected {ext, vector} and runs one acknowledge
    task automatic ack(input string req, input logic [2:0] lvl,
                       input logic ext, input logic [7:0] v);
        expq.push_back({ext, v});
        tagq.push_back(req);
        @(negedge clk);
        iack = 1'b1; iack_lvl = lvl;
        @(negedge clk);
        chk("R12 not yet valid", {14'd0, vec_vld, ext_vec}, 16'd0);
        repeat (2) @(negedge clk);
        iack = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        sys_rst_n = 1'b1; rst_n = 1'b1;
        // reset state
        see_ipl("R10 reset ipl", 3'd0);
        rd("R1 reset mode", 2'd0, 16'h0000);
        rd("R3 reset mask", 2'd2, 16'h0000);

        // R2: vector before any mode write
        wr(2'd2, 16'h00FF);
        pulse(3);
        see_ipl("R4 internal level", 3'd4);
        ack("R2 placeholder vector", 3'd4, 1'b0, 8'h0F);
        rd("R5 in-service set", 2'd3, 16'h0008);
        rd("R5 pending cleared", 2'd1, 16'h0000);

        // R3: masked source recorded but silent
        wr(2'd2, 16'h00DF);
        pulse(5);
        rd("R3 masked pending recorded", 2'd1, 16'h0020);
        see_ipl("R3 masked no request", 3'd0);

        // R4/R5 with vector base 101
        wr(2'd0, 16'h00A0);
        wr(2'd3, 16'h0008);
        rd("R5 write-1 clears in-service", 2'd3, 16'h0000);
        wr(2'd2, 16'h00FF);
        see_ipl("R4 unmasked raises", 3'd4);
        ack("R4 internal vector", 3'd4, 1'b0, 8'hA5);

        // R6 nesting
        pulse(2);
        see_ipl("R6 lower blocked", 3'd0);
        pulse(7);
        see_ipl("R6 higher nests", 3'd4);
        ack("R4 highest index wins", 3'd4, 1'b0, 8'hA7);
        wr(2'd3, 16'h00A0);
        ack("R6 lower after release", 3'd4, 1'b0, 8'hA2);
        wr(2'd3, 16'h0004);
        wr(2'd1, 16'h00FF);
        rd("R5 write-1 clears pending", 2'd1, 16'h0000);

        // R7 encoded pins
        @(negedge clk); irq_pin_n = 3'b001;
        see_ipl("R7 encoded level", 3'd6);
        ack("R7 external vector", 3'd6, 1'b1, 8'h00);
        @(negedge clk); irq_pin_n = 3'b111;
        see_ipl("R10 idle", 3'd0);

        // R8/R9 dedicated: L7 edge+internal, L6 level+external, L1 level+internal
        wr(2'd0, 16'hA4A0);
        rd("R1 mode readback", 2'd0, 16'hA4A0);
        @(negedge clk); irq_pin_n = 3'b011;
        @(negedge clk); irq_pin_n = 3'b111;
        see_ipl("R8 edge latched", 3'd7);
        ack("R9 level 7 internal", 3'd7, 1'b0, 8'hBF);
        see_ipl("R8 latch cleared by ack", 3'd0);
        @(negedge clk); irq_pin_n = 3'b101;
        see_ipl("R8 level line", 3'd6);
        ack("R9 level 6 external", 3'd6, 1'b1, 8'h00);
        @(negedge clk); irq_pin_n = 3'b111;
        see_ipl("R8 level line released", 3'd0);
        @(negedge clk); irq_pin_n = 3'b110;
        see_ipl("R8 level 1 line", 3'd1);
        pulse(1);
        see_ipl("R10 highest level wins", 3'd4);
        ack("R4 internal over line", 3'd4, 1'b0, 8'hA1);
        see_ipl("R10 line after nesting", 3'd1);
        ack("R9 level 1 internal", 3'd1, 1'b0, 8'hBD);
        @(negedge clk); irq_pin_n = 3'b111;
        wr(2'd3, 16'h0002);

        // R11 spurious
        ack("R11 spurious", 3'd3, 1'b0, 8'hBC);

        // R1 reserved bits and resets
        wr(2'd0, 16'hFFFF);
        rd("R1 reserved bits zero", 2'd0, 16'hF7E0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd("R1 mode survives soft reset", 2'd0, 16'hF7E0);
        rd("R3 mask cleared by soft reset", 2'd2, 16'h0000);
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        rd("R1 full reset clears mode", 2'd0, 16'h0000);

        repeat (2) @(negedge clk);
        chk("R12 all results seen", 16'(expq.size()), 16'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule